// File: doc/BRIEF.md
# MDIO Management Clock and Frame Engine

This block derives the management data clock (MDC) for a PHY management link from the system clock, and shifts read and write management frames out on the MDIO line. A six-bit divide field sets the clock rate: each MDC half-period lasts twice the field value in system clock cycles, so the full period is four times the field. A field of zero parks MDC low, and no frame can start while it is zero. A change to the field mid-run only affects the half-period that begins at the next MDC edge, so no half-period is ever cut short or stretched.

A frame is requested with a one-cycle `start` pulse that carries the opcode, the PHY address, the register address and the write data. An optional run of 32 ones comes first, unless `no_preamble` is set. Next come the start pattern 01, the opcode (01 write, 10 read), both addresses, a two-bit turnaround, and sixteen data bits. Output data changes on MDC falling edges. Read data is sampled on MDC rising edges. `done` pulses for one cycle when the frame ends.

The frame controller has six states. IDLE accepts a request (IDLE→ALIGN) only when the divide field is non-zero. ALIGN waits for an MDC falling edge and then goes to PREAMBLE, or straight to HEADER when the preamble is disabled. PREAMBLE→HEADER follows the 32nd one. HEADER→TURN follows the 14th header bit. TURN→DATA follows the second turnaround bit. DATA→IDLE is taken at the falling edge that ends the last data bit, and this transition raises `done`.

Top module: `mdio_engine`

## Requirements
- R1: For every divide field value d from 1 to 63, MDC is high for 2·d and low for 2·d system clock cycles, giving a period of 4·d cycles.
- R2: While the divide field is zero, MDC is held low.
- R3: A `start` pulse has no effect while the divide field is zero, or while a frame is in progress. No frame begins and no later `done` appears because of it.
- R4: A divide field change made partway through an MDC half-period does not alter that half-period. The next half-period has the new length.
- R5: With `no_preamble` low, a frame begins with 32 driven ones. With it high, the frame begins directly with the start pattern.
- R6: After any preamble, the driven bits in order are: 0, 1, the 2-bit opcode, the 5-bit PHY address, the 5-bit register address, and the turnaround. Each field is sent MSB first. A write frame is 32 bits long after the preamble.
- R7: For a write (any opcode other than 10), the turnaround is driven as 1 then 0, and the 16 write data bits follow MSB first with `mdio_oe` high. For a read (opcode 10), `mdio_oe` is low from the first turnaround bit to the end of the frame.
- R8: `mdio_o` and `mdio_oe` change only on MDC falling edges, never on a rising edge.
- R9: A read captures `mdio_i` at the 16 MDC rising edges of the data phase, MSB first. The result appears on `rd_data` when `done` pulses. A write leaves `rd_data` unchanged.
- R10: `done` is high for exactly one system clock cycle. That cycle coincides with the MDC falling edge that ends the last data bit.
- R11: During reset, MDC, `mdio_o`, `mdio_oe` and `done` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| div_field | input | 6 | MDC divide field; zero stops MDC |
| no_preamble | input | 1 | Omit the 32-bit preamble when high |
| start | input | 1 | One-cycle frame request |
| op | input | 2 | Opcode, 01 write, 10 read |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| mdio_i | input | 1 | MDIO input from pad |
| mdc | output | 1 | Management data clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| rd_data | output | 16 | Data captured by the last read |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A corrupted divide counter shows at once on MDC as a wrong half-period length, within one half-period of the fault. A wrong frame state or bit counter gives a bit stream that is shifted, too short or too long. It also puts the release of `mdio_oe` at the wrong bit, and this is visible by the next MDC rising edge. A wrong receive shift shows only when `done` pulses, as a bad `rd_data` value. A stale state can also leave `done` missing, which shows when the frame runs past its expected length.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA
    } frame_state_t;

    localparam logic [1:0] OP_READ   = 2'b10;
    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] TA_WRITE  = 2'b10;
    localparam int         TA_BITS   = 2;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             run,
    output logic             rise_tick,
    output logic             fall_tick
);

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic             expired;

    assign run       = (div != '0);
    assign expired   = run && (cnt == '0);
    assign rise_tick = expired && !mdc;
    assign fall_tick = expired && mdc;

    // Half-period length is sampled only when MDC toggles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (expired) begin
            mdc <= ~mdc;
            cnt <= {div, 1'b0} - CNT_W'(1);
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assert_mdc_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    assert_toggle_on_expiry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> ($past(cnt) == '0));

    assert_count_ignores_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              no_preamble,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    localparam int HDR_BITS = 4 + 2 * ADDR_W;
    localparam int SR_W     = HDR_BITS + TA_BITS + DATA_W;
    localparam int MAX_SEG  = (PRE_LEN > SR_W) ? PRE_LEN : SR_W;
    localparam int CNT_W    = $clog2(MAX_SEG);

    frame_state_t      state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SR_W-1:0]   sr;
    logic [DATA_W-1:0] rx;
    logic              is_rd;
    logic              skip_pre;
    logic              seg_end;
    logic              msb;
    logic              accept;

    assign seg_end = fall_tick && (bit_cnt == '0);
    assign msb     = sr[SR_W-1];
    assign accept  = (state == ST_IDLE) && start && run;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept)    state_nx = ST_ALIGN;
            ST_ALIGN: if (fall_tick) state_nx = skip_pre ? ST_HDR : ST_PRE;
            ST_PRE:   if (seg_end)   state_nx = ST_HDR;
            ST_HDR:   if (seg_end)   state_nx = ST_TURN;
            ST_TURN:  if (seg_end)   state_nx = ST_DATA;
            ST_DATA:  if (seg_end)   state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            sr       <= '0;
            rx       <= '0;
            is_rd    <= 1'b0;
            skip_pre <= 1'b0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                sr       <= {START_PAT, op, phy_addr, reg_addr,
                             (op == OP_READ) ? 2'b00 : TA_WRITE, wr_data};
                is_rd    <= (op == OP_READ);
                skip_pre <= no_preamble;
            end
            if (rise_tick && state == ST_DATA && is_rd)
                rx <= {rx[DATA_W-2:0], mdio_i};
            if (fall_tick) begin
                unique case (state)
                    ST_ALIGN: begin
                        mdio_oe <= 1'b1;
                        if (skip_pre) begin
                            bit_cnt <= CNT_W'(HDR_BITS - 1);
                            mdio_o  <= msb;
                            sr      <= sr << 1;
                        end else begin
                            bit_cnt <= CNT_W'(PRE_LEN - 1);
                            mdio_o  <= 1'b1;
                        end
                    end
                    ST_PRE: begin
                        if (bit_cnt != '0) begin
                            bit_cnt <= bit_cnt - CNT_W'(1);
                            mdio_o  <= 1'b1;
                        end else begin
                            bit_cnt <= CNT_W'(HDR_BITS - 1);
                            mdio_o  <= msb;
                            sr      <= sr << 1;
                        end
                    end
                    ST_HDR: begin
                        sr <= sr << 1;
                        if (bit_cnt != '0) begin
                            bit_cnt <= bit_cnt - CNT_W'(1);
                            mdio_o  <= msb;
                        end else begin
                            bit_cnt <= CNT_W'(TA_BITS - 1);
                            mdio_oe <= !is_rd;
                            mdio_o  <= msb && !is_rd;
                        end
                    end
                    ST_TURN: begin
                        sr      <= sr << 1;
                        mdio_o  <= msb && !is_rd;
                        bit_cnt <= (bit_cnt != '0) ? bit_cnt - CNT_W'(1)
                                                   : CNT_W'(DATA_W - 1);
                    end
                    ST_DATA: begin
                        if (bit_cnt != '0) begin
                            sr      <= sr << 1;
                            bit_cnt <= bit_cnt - CNT_W'(1);
                            mdio_o  <= msb && !is_rd;
                        end else begin
                            done    <= 1'b1;
                            mdio_o  <= 1'b0;
                            mdio_oe <= 1'b0;
                            if (is_rd) rd_data <= rx;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_from_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_DATA));

    assert_mdio_hold_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_no_start_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !run) |=> (state == ST_IDLE));

    assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && (state == ST_DATA || state == ST_TURN)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine #(
    parameter int DIV_W   = 6,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_field,
    input  logic              no_preamble,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    logic run;
    logic rise_tick;
    logic fall_tick;

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (div_field),
        .mdc       (mdc),
        .run       (run),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PRE_LEN (PRE_LEN)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .rise_tick   (rise_tick),
        .fall_tick   (fall_tick),
        .no_preamble (no_preamble),
        .start       (start),
        .op          (op),
        .phy_addr    (phy_addr),
        .reg_addr    (reg_addr),
        .wr_data     (wr_data),
        .mdio_i      (mdio_i),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .rd_data     (rd_data),
        .done        (done)
    );

endmodule

// File: tb/tb_mdio_engine.sv
module tb_mdio_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  div_field = 6'd0;
    logic        no_preamble = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [4:0]  phy_addr = 5'd0;
    logic [4:0]  reg_addr = 5'd0;
    logic [15:0] wr_data = 16'd0;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe, done;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 0;

    bit        cap_on = 0;
    int        cap_n = 0;
    bit        cap_oe [0:79];
    bit        cap_o  [0:79];
    bit        rd_mode = 0;
    logic [15:0] rd_val = 16'd0;
    int        pre_len = 32;

    mdio_engine dut (
        .clk(clk), .rst_n(rst_n), .div_field(div_field), .no_preamble(no_preamble),
        .start(start), .op(op), .phy_addr(phy_addr), .reg_addr(reg_addr),
        .wr_data(wr_data), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .rd_data(rd_data), .done(done)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (rst_n && done) done_cnt++;

    // PHY model: records each MDC rising edge, then drives the next read bit.
    always @(posedge mdc) begin
        if (cap_on) begin
            if ((cap_n > 0 || mdio_oe) && cap_n < 80) begin
                cap_oe[cap_n] = mdio_oe;
                cap_o[cap_n]  = mdio_o;
                cap_n++;
            end
            #1;
            if (rd_mode && cap_n >= pre_len + 16 && cap_n < pre_len + 32)
                mdio_i = rd_val[15 - (cap_n - pre_len - 16)];
            else
                mdio_i = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sync_rise();
        do @(negedge clk); while (mdc != 1'b0);
        do @(negedge clk); while (mdc != 1'b1);
    endtask

    task automatic run_frame(input logic [5:0] d, input bit skip, input logic [1:0] o,
                             input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] rv, input bit poke);
        logic [31:0] exp_sr;
        int   wait_cyc;
        int   bad;
        int   dc0;
        bit   prev_mdc;
        bit   done_ok;
        bit   rd;
        logic [15:0] rd_before;
        rd = (o == 2'b10);
        rd_before = rd_data;
        @(negedge clk);
        div_field = d; no_preamble = skip; op = o; phy_addr = pa;
        reg_addr = ra; wr_data = wd;
        pre_len = skip ? 0 : 32; rd_mode = rd; rd_val = rv;
        cap_n = 0; cap_on = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cyc = 0; done_ok = 0; prev_mdc = mdc;
        while (!done && wait_cyc < 4 * 64 * 80) begin
            if (poke && wait_cyc == 60) begin
                op = 2'b01; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
                start = 1'b1;
            end else start = 1'b0;
            prev_mdc = mdc;
            @(negedge clk);
            wait_cyc++;
        end
        start = 1'b0;
        cap_on = 0;
        // R10: done at the falling MDC edge
        chk(done && prev_mdc && !mdc, "R10 done at MDC fall", int'(done), 1);
        @(negedge clk);
        chk(!done, "R10 done single cycle", int'(done), 0);
        // R5 R6: frame length
        chk(cap_n == pre_len + 32, "R6 frame bit count", cap_n, pre_len + 32);
        exp_sr = {2'b01, o, pa, ra, rd ? 2'b00 : 2'b10, wd};
        bad = -1;
        for (int i = 0; i < pre_len + 32 && i < cap_n; i++) begin
            bit eo, eb;
            if (i < pre_len) begin eo = 1; eb = 1; end
            else begin
                eo = !(rd && (i - pre_len) >= 14);
                eb = exp_sr[31 - (i - pre_len)];
            end
            if (bad < 0 && (cap_oe[i] != eo || (eo && cap_o[i] != eb))) bad = i;
        end
        chk(bad < 0, "R5 R6 R7 bit stream first mismatch index", bad, -1);
        if (rd) chk(rd_data == rv, "R9 read data", int'(rd_data), int'(rv));
        else    chk(rd_data == rd_before, "R9 write keeps rd_data", int'(rd_data), int'(rd_before));
        if (poke) begin
            dc0 = done_cnt;
            repeat (400) @(negedge clk);
            chk(done_cnt == dc0 && !mdio_oe, "R3 start during frame ignored", done_cnt - dc0, 0);
        end
    endtask

    initial begin
        int hi, lo;
        int bad;
        int dc0;
        repeat (3) @(negedge clk);
        // R11
        chk(mdc == 0 && mdio_o == 0 && mdio_oe == 0 && done == 0 && rd_data == 0,
            "R11 reset state", int'(rd_data), 0);
        rst_n = 1'b1;

        // R1: exhaustive divide sweep
        for (int d = 1; d < 64; d++) begin
            @(negedge clk); div_field = 6'(d);
            sync_rise();
            hi = 0; while (mdc == 1) begin hi++; @(negedge clk); end
            lo = 0; while (mdc == 0) begin lo++; @(negedge clk); end
            chk(hi == 2 * d, $sformatf("R1 high time div=%0d", d), hi, 2 * d);
            chk(lo == 2 * d, $sformatf("R1 low time div=%0d", d), lo, 2 * d);
        end

        // R4: change mid half-period
        @(negedge clk); div_field = 6'd4;
        sync_rise();
        hi = 0;
        while (mdc == 1) begin
            hi++;
            if (hi == 3) div_field = 6'd1;
            @(negedge clk);
        end
        lo = 0; while (mdc == 0) begin lo++; @(negedge clk); end
        chk(hi == 8, "R4 running half-period keeps old length", hi, 8);
        chk(lo == 2, "R4 next half-period uses new length", lo, 2);

        // R2 R3: stopped clock
        @(negedge clk); div_field = 6'd0;
        repeat (2) @(negedge clk);
        dc0 = done_cnt; bad = 0;
        op = 2'b01; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 150; i++) begin
            if (mdc || mdio_oe) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R2 MDC parked low at zero divide", bad, 0);
        div_field = 6'd1;
        repeat (400) @(negedge clk);
        chk(done_cnt == dc0, "R3 start ignored while stopped", done_cnt - dc0, 0);

        // Frames
        run_frame(6'd1, 0, 2'b01, 5'h15, 5'h0A, 16'hA55A, 16'h0000, 0);
        run_frame(6'd1, 1, 2'b01, 5'h1F, 5'h00, 16'h8001, 16'h0000, 0);
        run_frame(6'd2, 0, 2'b10, 5'h03, 5'h1C, 16'h0000, 16'hC3A5, 0);
        run_frame(6'd3, 1, 2'b10, 5'h10, 5'h01, 16'h0000, 16'h5A0F, 0);
        run_frame(6'd1, 0, 2'b01, 5'h0C, 5'h13, 16'h1234, 16'h0000, 1);
        run_frame(6'd2, 1, 2'b10, 5'h01, 5'h1E, 16'h0000, 16'hFFFE, 0);
        run_frame(6'd1, 1, 2'b11, 5'h0A, 5'h05, 16'h7E81, 16'h0000, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule